// File: doc/BRIEF.md
# Condition Handshake Mailbox Between a Bit Processor and a Word Processor

This block lets a single-bit logic processor and a byte-wide processor, each running its own program at the same time, hand one-bit logic results to each other. Each direction has its own one-entry mailbox per task. The producer writes the condition bit into the mailbox. The consumer later reads it into its own condition register. Each mailbox remembers whether it holds an unread value.

A processor is told to wait only in two cases. It waits when it tries to read a mailbox that holds nothing. It also waits when it tries to write a mailbox whose previous value nobody has read yet. Otherwise both processors run freely.

Traffic is split into independent tasks, chosen by a task index on each side. A wait on one task's mailbox has no effect on the mailboxes of any other task. The wait outputs are combinational from the selected mailbox's state, so the processor can hold its instruction in the same cycle it issues it.

Top module: `cond_mbox`

## Requirements
- R1: After reset every mailbox in both directions is empty with a stored bit of 0, and both condition outputs are 0.
- R2: A write to an empty mailbox stores the input bit on the clock edge and marks the mailbox full.
- R3: A read of a full mailbox loads the stored bit into the reader's condition output on the clock edge and marks the mailbox empty. The condition output changes only on such an accepted read.
- R4: A write to a full mailbox raises the writer's write-stall output in the same cycle. The stored bit and the full state are unchanged.
- R5: A read of an empty mailbox raises the reader's read-stall output in the same cycle. The reader's condition output is unchanged.
- R6: A stall output is 0 in any cycle in which its strobe is 0.
- R7: The bit-to-word direction (written by the bit side, read by the word side) and the word-to-bit direction (written by the word side, read by the bit side) are independent storage.
- R8: Each of the 8 tasks, selected by a 3-bit index (0 to 7) on each side, has its own pair of mailboxes. Filling or draining one task's mailbox never changes the stall outcome or data of another task.
- R9: When a read and a write hit the same full mailbox in one cycle, the read is accepted and the write stalls. A repeated write in the next cycle is accepted, so no value is lost or duplicated.
- R10: When a read and a write hit the same empty mailbox in one cycle, the write is accepted and the read stalls. The repeated read in the next cycle returns the written bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_sel | input | 3 | Task index for the bit-side access |
| lp_wr | input | 1 | Bit side writes its bit into the bit-to-word mailbox |
| lp_cin | input | 1 | Condition bit from the bit side |
| lp_rd | input | 1 | Bit side reads the word-to-bit mailbox |
| lp_cout | output | 1 | Bit-side condition register, loaded by accepted reads |
| lp_wr_stall | output | 1 | Bit-side write must wait (mailbox full) |
| lp_rd_stall | output | 1 | Bit-side read must wait (mailbox empty) |
| wp_sel | input | 3 | Task index for the word-side access |
| wp_wr | input | 1 | Word side writes its bit into the word-to-bit mailbox |
| wp_cin | input | 1 | Condition bit from the word side |
| wp_rd | input | 1 | Word side reads the bit-to-word mailbox |
| wp_cout | output | 1 | Word-side condition register, loaded by accepted reads |
| wp_wr_stall | output | 1 | Word-side write must wait (mailbox full) |
| wp_rd_stall | output | 1 | Word-side read must wait (mailbox empty) |

## Verification
The hardest situation to reach is a single cycle in which the producer and the consumer aim at the same task's mailbox. It has to occur once with the mailbox full and once with it empty, and the follow-up retry has to come on the very next cycle. With random task indices this collision happens only rarely. Directed sequences therefore first prime a chosen task's mailbox and then issue the colliding pair. The random phase draws both task indices from a narrowed range much of the time, so collisions recur across many mailbox states.

// File: rtl/cmb_pkg.sv
// Shared sizing for the condition mailbox.
// Assumes the task count is a power of two so every index value names a task.
package cmb_pkg;
    localparam int CMB_TASKS = 8;
    localparam int CMB_SEL_W = $clog2(CMB_TASKS);

    // State of one mailbox entry.
    typedef struct packed {
        logic full;
        logic bit_q;
    } cmb_slot_t;
endpackage

// File: rtl/cmb_cell.sv
// One-entry, one-bit mailbox.
// Assumes the enclosing bank never asserts put and take together
// (put requires empty, take requires full).
module cmb_cell
    import cmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      put,
    input  logic      take,
    input  logic      din,
    output cmb_slot_t slot
);
    // Hold the bit and its occupancy; a put fills, a take drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot.full  <= 1'b0;
            slot.bit_q <= 1'b0;
        end else if (put) begin
            slot.full  <= 1'b1;
            slot.bit_q <= din;
        end else if (take) begin
            slot.full  <= 1'b0;
        end
    end
endmodule

// File: rtl/cmb_bank.sv
// One direction of the mailbox: a cell per task, a writer port and a reader port.
// Stalls are combinational from the addressed cell; a write stalls on full,
// a read stalls on empty, so one cell never sees a put and a take together.
module cmb_bank
    import cmb_pkg::*;
#(
    parameter  int NCH   = CMB_TASKS,
    localparam int SEL_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_bit,
    input  logic             rd_req,
    input  logic [SEL_W-1:0] rd_sel,
    output logic             wr_stall,
    output logic             rd_stall,
    output logic             rd_go,
    output logic             rd_bit
);
    cmb_slot_t        slots [NCH];
    logic [NCH-1:0]   full_v;
    logic [NCH-1:0]   bit_v;
    logic             wr_go;

    // Flatten the cell state for indexed access.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            full_v[i] = slots[i].full;
            bit_v[i]  = slots[i].bit_q;
        end
    end

    // Accept or stall each side from the addressed cell's occupancy.
    always_comb begin
        wr_stall = wr_req &  full_v[wr_sel];
        wr_go    = wr_req & ~full_v[wr_sel];
        rd_stall = rd_req & ~full_v[rd_sel];
        rd_go    = rd_req &  full_v[rd_sel];
        rd_bit   = bit_v[rd_sel];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_cell
        logic put_g;
        logic take_g;

        // Route accepted accesses to the addressed cell only.
        always_comb begin
            put_g  = wr_go && (wr_sel == SEL_W'(g));
            take_g = rd_go && (rd_sel == SEL_W'(g));
        end

        cmb_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .put  (put_g),
            .take (take_g),
            .din  (wr_bit),
            .slot (slots[g])
        );
    end
endmodule

// File: rtl/cmb_cond_reg.sv
// Condition register of one processor, loaded only by an accepted read.
module cmb_cond_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    output logic q
);
    // Capture the mailbox bit when the read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/cond_mbox.sv
// Two-direction condition mailbox between a bit-side and a word-side processor.
// Each side writes into its own outbound bank and reads from the inbound bank.
// Assumes each processor holds its strobe while the matching stall is high.
module cond_mbox
    import cmb_pkg::*;
#(
    parameter  int NTASK = CMB_TASKS,
    localparam int SEL_W = $clog2(NTASK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] lp_sel,
    input  logic             lp_wr,
    input  logic             lp_cin,
    input  logic             lp_rd,
    output logic             lp_cout,
    output logic             lp_wr_stall,
    output logic             lp_rd_stall,
    input  logic [SEL_W-1:0] wp_sel,
    input  logic             wp_wr,
    input  logic             wp_cin,
    input  logic             wp_rd,
    output logic             wp_cout,
    output logic             wp_wr_stall,
    output logic             wp_rd_stall
);
    logic l2w_go, l2w_bit;
    logic w2l_go, w2l_bit;

    // Bit side produces, word side consumes.
    cmb_bank #(.NCH(NTASK)) u_l2w (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (lp_wr),
        .wr_sel  (lp_sel),
        .wr_bit  (lp_cin),
        .rd_req  (wp_rd),
        .rd_sel  (wp_sel),
        .wr_stall(lp_wr_stall),
        .rd_stall(wp_rd_stall),
        .rd_go   (l2w_go),
        .rd_bit  (l2w_bit)
    );

    // Word side produces, bit side consumes.
    cmb_bank #(.NCH(NTASK)) u_w2l (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wp_wr),
        .wr_sel  (wp_sel),
        .wr_bit  (wp_cin),
        .rd_req  (lp_rd),
        .rd_sel  (lp_sel),
        .wr_stall(wp_wr_stall),
        .rd_stall(lp_rd_stall),
        .rd_go   (w2l_go),
        .rd_bit  (w2l_bit)
    );

    cmb_cond_reg u_wp_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (l2w_go),
        .din  (l2w_bit),
        .q    (wp_cout)
    );

    cmb_cond_reg u_lp_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (w2l_go),
        .din  (w2l_bit),
        .q    (lp_cout)
    );
endmodule

// File: rtl/cmb_checker.sv
// Port-level properties of the condition mailbox, bound to every instance.
module cmb_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] lp_sel,
    input logic             lp_wr,
    input logic             lp_cin,
    input logic             lp_rd,
    input logic             lp_cout,
    input logic             lp_wr_stall,
    input logic             lp_rd_stall,
    input logic [SEL_W-1:0] wp_sel,
    input logic             wp_wr,
    input logic             wp_cin,
    input logic             wp_rd,
    input logic             wp_cout,
    input logic             wp_wr_stall,
    input logic             wp_rd_stall
);
    // R6: no stall without its strobe.
    a_r6_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_wr_stall && !lp_wr) && !(lp_rd_stall && !lp_rd) &&
        !(wp_wr_stall && !wp_wr) && !(wp_rd_stall && !wp_rd));

    // R1: first cycle out of reset, every mailbox is empty.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && wp_rd |-> wp_rd_stall);

    // R3 / R5: condition output moves only after an accepted read.
    a_r3_wp_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_rd && !wp_rd_stall) |=> $stable(wp_cout));
    a_r5_lp_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_rd && !lp_rd_stall) |=> $stable(lp_cout));

    // R4: a just-filled mailbox stalls the next write to it.
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(lp_wr && !lp_wr_stall) && lp_wr &&
        lp_sel == $past(lp_sel) |-> lp_wr_stall);

    // R5: a just-drained mailbox stalls the next read of it.
    a_r5_no_double_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wp_rd && !wp_rd_stall) && wp_rd &&
        wp_sel == $past(wp_sel) |-> wp_rd_stall);

    // R2 / R3: a write followed by an accepted read delivers the written bit.
    a_r2_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(lp_wr && !lp_wr_stall) && wp_rd && !wp_rd_stall &&
        wp_sel == $past(lp_sel) |=> wp_cout == $past(lp_cin, 2));

    // R9: read wins a full-mailbox collision, write goes through next cycle.
    a_r9_collide_full: assert property (@(posedge clk) disable iff (!rst_n)
        wp_rd && !wp_rd_stall && lp_wr && lp_sel == wp_sel |-> lp_wr_stall);
    a_r9_retry_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wp_rd && !wp_rd_stall && lp_wr && lp_sel == wp_sel) &&
        lp_wr && lp_sel == $past(lp_sel) |-> !lp_wr_stall);
endmodule

bind cond_mbox cmb_checker #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_cond_mbox.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared against a behavioural mailbox model kept in the bench.
module sim_cond_mbox;
    localparam int NT = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] lp_sel, wp_sel;
    logic       lp_wr, lp_cin, lp_rd, wp_wr, wp_cin, wp_rd;
    logic       lp_cout, lp_wr_stall, lp_rd_stall;
    logic       wp_cout, wp_wr_stall, wp_rd_stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model state: a = bit-to-word, b = word-to-bit.
    bit m_full_a [NT];
    bit m_bit_a  [NT];
    bit m_full_b [NT];
    bit m_bit_b  [NT];
    bit exp_lp, exp_wp;

    always #10 clk = ~clk;

    cond_mbox u0 (.*);

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_stall_wr(bit req, bit full);
        return req & full;
    endfunction

    function automatic bit exp_stall_rd(bit req, bit full);
        return req & ~full;
    endfunction

    // One cycle: drive, check stalls, update model, check outputs after the edge.
    task automatic step(string tag, bit lw, bit lr, logic [2:0] ls, bit lc,
                        bit ww, bit wr, logic [2:0] ws, bit wc);
        bit elws, elrs, ewws, ewrs;
        @(negedge clk);
        lp_wr = lw; lp_rd = lr; lp_sel = ls; lp_cin = lc;
        wp_wr = ww; wp_rd = wr; wp_sel = ws; wp_cin = wc;
        #1;
        elws = exp_stall_wr(lw, m_full_a[ls]);
        elrs = exp_stall_rd(lr, m_full_b[ls]);
        ewws = exp_stall_wr(ww, m_full_b[ws]);
        ewrs = exp_stall_rd(wr, m_full_a[ws]);
        chk(tag, "R4 lp_wr_stall", lp_wr_stall, elws);
        chk(tag, "R5 lp_rd_stall", lp_rd_stall, elrs);
        chk(tag, "R4 wp_wr_stall", wp_wr_stall, ewws);
        chk(tag, "R5 wp_rd_stall", wp_rd_stall, ewrs);
        if (lr && !elrs) begin exp_lp = m_bit_b[ls]; m_full_b[ls] = 1'b0; end
        if (wr && !ewrs) begin exp_wp = m_bit_a[ws]; m_full_a[ws] = 1'b0; end
        if (lw && !elws) begin m_full_a[ls] = 1'b1; m_bit_a[ls] = lc; end
        if (ww && !ewws) begin m_full_b[ws] = 1'b1; m_bit_b[ws] = wc; end
        @(posedge clk);
        #1;
        chk(tag, "R3 lp_cout", lp_cout, exp_lp);
        chk(tag, "R3 wp_cout", wp_cout, exp_wp);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 3'd0, 0, 0, 0, 3'd0, 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        lp_wr = 0; lp_rd = 0; lp_sel = 0; lp_cin = 0;
        wp_wr = 0; wp_rd = 0; wp_sel = 0; wp_cin = 0;
        for (int i = 0; i < NT; i++) begin
            m_full_a[i] = 0; m_bit_a[i] = 0; m_full_b[i] = 0; m_bit_b[i] = 0;
        end
        exp_lp = 0; exp_wp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "lp_cout after reset", lp_cout, 1'b0);
        chk("R1", "wp_cout after reset", wp_cout, 1'b0);
        rst_n = 1'b1;

        // R1: reads of every task stall right after reset.
        for (int t = 0; t < NT; t++) step("R1", 0, 1, 3'(t), 0, 0, 1, 3'(t), 0);

        // R2 / R3: write then read in each direction.
        step("R2", 1, 0, 3'd1, 1, 0, 0, 3'd0, 0);
        step("R3", 0, 0, 3'd0, 0, 0, 1, 3'd1, 0);
        step("R2", 0, 0, 3'd0, 0, 1, 0, 3'd4, 1);
        step("R3", 0, 1, 3'd4, 0, 0, 0, 3'd0, 0);

        // R4: second write to a full mailbox stalls and keeps the first bit.
        step("R4", 1, 0, 3'd5, 1, 0, 0, 3'd0, 0);
        step("R4", 1, 0, 3'd5, 0, 0, 0, 3'd0, 0);
        step("R4", 0, 0, 3'd0, 0, 0, 1, 3'd5, 0);

        // R5: read of an empty mailbox stalls and keeps the output.
        step("R5", 0, 0, 3'd0, 0, 0, 1, 3'd5, 0);

        // R7: same task index used in both directions at once.
        step("R7", 1, 0, 3'd6, 1, 1, 0, 3'd6, 0);
        step("R7", 0, 1, 3'd6, 0, 0, 1, 3'd6, 0);

        // R8: fill all tasks with a pattern, then drain in reverse order.
        for (int t = 0; t < NT; t++) step("R8", 1, 0, 3'(t), bit'((t * 5) >> 1), 0, 0, 3'd0, 0);
        step("R8", 1, 0, 3'd3, 0, 0, 0, 3'd0, 0);
        for (int t = NT - 1; t >= 0; t--) step("R8", 0, 0, 3'd0, 0, 0, 1, 3'(t), 0);

        // R9: full-mailbox collision, then retry of the write.
        step("R9", 1, 0, 3'd2, 1, 0, 0, 3'd0, 0);
        step("R9", 1, 0, 3'd2, 0, 0, 1, 3'd2, 0);
        step("R9", 1, 0, 3'd2, 0, 0, 0, 3'd0, 0);
        step("R9", 0, 0, 3'd0, 0, 0, 1, 3'd2, 0);

        // R10: empty-mailbox collision, then retry of the read.
        step("R10", 0, 1, 3'd3, 0, 1, 0, 3'd3, 1);
        step("R10", 0, 1, 3'd3, 0, 0, 0, 3'd0, 0);

        // R6: no strobes, no stalls.
        idle("R6");

        // Random traffic; narrow task range half the time to force collisions.
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] ls, ws;
            if ($urandom_range(1) == 0) begin
                ls = 3'($urandom_range(1)); ws = 3'($urandom_range(1));
            end else begin
                ls = 3'($urandom); ws = 3'($urandom);
            end
            step("RND", bit'($urandom), bit'($urandom), ls, bit'($urandom),
                 bit'($urandom), bit'($urandom), ws, bit'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule